// File: doc/BRIEF.md
# Counter-Addressed Feedback Delay Memory

This block is the feedback storage for one stage of a single-path delay-feedback FFT pipeline. It holds `DEPTH` complex words. The words stay in fixed registers, and a wrapping pointer selects the entry to use. Each valid cycle reads the entry at the pointer onto the output. In the same cycle the block overwrites that entry with a new word. Only the addressed register receives a write enable, so the other entries do not toggle.

A stage control input selects the word written back. It is either the butterfly difference result or the raw incoming sample. In a 64-point pipeline the six stages use depths of 32, 16, 8, 4, 2 and 1, so each stage has half the depth of the one before it. A depth of one becomes a single enabled register with no pointer logic. Cycles with the valid input low are stalls: they change nothing.

Top module: `fft_fb_delay`

## Requirements
- R1: While reset is asserted, and on the first valid cycle after reset, `dout_vld` is 0. Reset sets the pointer to entry 0.
- R2: `dout_vld` stays 0 until `DEPTH` valid words have been written since reset. From then on, every valid cycle has `dout_vld` = 1.
- R3: On a valid cycle with `dout_vld` = 1, `{dout_re, dout_im}` equals the word written exactly `DEPTH` valid cycles earlier.
- R4: The word stored on a valid cycle is `{dif_re, dif_im}` when `src_sel` = 1 and `{smp_re, smp_im}` when `src_sel` = 0.
- R5: On a cycle with `smp_vld` = 0, `dout_vld` is 0. Neither the stored words nor the pointer change, so the delay counts valid cycles only.
- R6: The pointer advances by one on each valid cycle and wraps from `DEPTH`-1 to 0.
- R7: On each cycle at most one entry is enabled for writing, and that entry is the one at the pointer. No entry is enabled on a stall. Every other stored word is left unchanged.
- R8: With `DEPTH` = 1 the block acts as a single enabled register: each valid output is the word written on the previous valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | Valid strobe for the incoming word; low means stall |
| src_sel | input | 1 | 1 stores the difference word, 0 stores the incoming sample |
| smp_re | input | W | Incoming sample, real part |
| smp_im | input | W | Incoming sample, imaginary part |
| dif_re | input | W | Butterfly difference, real part |
| dif_im | input | W | Butterfly difference, imaginary part |
| dout_re | output | W | Delayed word, real part |
| dout_im | output | W | Delayed word, imaginary part |
| dout_vld | output | 1 | Delayed word is valid |

## Verification
Two instances, one with depth 8 and one with depth 1, take the same stimulus. A queue model compares their outputs against a shift-register reference. An unbroken valid stream over several laps of the pointer shows whether the pointer wraps correctly and whether the delay is exact. Alternating `src_sel` shows whether the right source is stored. Random stall gaps separate a delay counted in valid cycles from one counted in clock cycles, and they expose any write that touches an entry other than the addressed one. A reset in the middle of a run confirms that the output valid flag stays low again until the buffer has been refilled.

// File: rtl/fft_fb_delay_pkg.sv
package fft_fb_delay_pkg;

  typedef enum logic {
    SRC_SAMPLE = 1'b0,
    SRC_DIFF   = 1'b1
  } wsrc_e;

  // pointer width, at least one bit
  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/fft_fb_delay_ptr.sv
module fft_fb_delay_ptr #(
  parameter int DEPTH = 32,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);

  generate
    if (DEPTH == 1) begin : g_none
      assign ptr = '0;
    end else begin : g_cnt
      logic [PW-1:0] ptr_q, ptr_d;

      always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
          if (ptr_q == PW'(DEPTH - 1)) ptr_d = '0;
          else                         ptr_d = ptr_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
      end

      assign ptr = ptr_q;
    end
  endgenerate

endmodule

// File: rtl/fft_fb_delay_fill.sv
module fft_fb_delay_fill #(
  parameter int DEPTH = 32,
  parameter int FW    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic primed
);

  logic [FW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full = (cnt_q == FW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (adv && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign primed = full;

endmodule

// File: rtl/fft_fb_delay_bank.sv
module fft_fb_delay_bank #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int PW    = 5
) (
  input  logic             clk,
  input  logic [DEPTH-1:0] wen,
  input  logic [DW-1:0]    wdata,
  input  logic [PW-1:0]    ptr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];

  // storage is not reset; each entry loads only when its own enable is set
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wen[i]) mem[i] <= wdata;
      end
    end

    if (DEPTH == 1) begin : g_rd1
      assign rdata = mem[0];
    end else begin : g_rdn
      assign rdata = mem[ptr];
    end
  endgenerate

endmodule

// File: rtl/fft_fb_delay.sv
module fft_fb_delay #(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic         src_sel,
  input  logic [W-1:0] smp_re,
  input  logic [W-1:0] smp_im,
  input  logic [W-1:0] dif_re,
  input  logic [W-1:0] dif_im,
  output logic [W-1:0] dout_re,
  output logic [W-1:0] dout_im,
  output logic         dout_vld
);
  import fft_fb_delay_pkg::*;

  localparam int PW = ptr_bits(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int DW = 2 * W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  logic [PW-1:0]    ptr;
  logic             primed;
  logic [DEPTH-1:0] wen;
  logic [DW-1:0]    wdata, rdata;
  wsrc_e            wsrc;

  fft_fb_delay_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_s), .adv(smp_vld), .ptr(ptr)
  );

  fft_fb_delay_fill #(.DEPTH(DEPTH), .FW(FW)) u_fill (
    .clk(clk), .rst_n(rst_s), .adv(smp_vld), .primed(primed)
  );

  // one enable per entry, gated by the valid strobe
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wen[i] = smp_vld && (ptr == PW'(i));
    end
  end

  assign wsrc  = wsrc_e'(src_sel);
  assign wdata = (wsrc == SRC_DIFF) ? {dif_re, dif_im} : {smp_re, smp_im};

  fft_fb_delay_bank #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_bank (
    .clk(clk), .wen(wen), .wdata(wdata), .ptr(ptr), .rdata(rdata)
  );

  assign dout_re  = rdata[DW-1:W];
  assign dout_im  = rdata[W-1:0];
  assign dout_vld = primed && smp_vld;

endmodule

// File: rtl/fft_fb_delay_chk.sv
module fft_fb_delay_chk #(
  parameter int DEPTH = 32,
  parameter int PW    = 5
) (
  input logic             clk,
  input logic             rst_s,
  input logic             smp_vld,
  input logic             dout_vld,
  input logic             primed,
  input logic [PW-1:0]    ptr,
  input logic [DEPTH-1:0] wen
);

  AST_STALL_NO_VLD: assert property (@(posedge clk) disable iff (!rst_s)
    !smp_vld |-> !dout_vld);                                     // R5

  AST_STALL_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !smp_vld |=> $stable(ptr));                                  // R5

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && ptr == PW'(DEPTH - 1)) |=> ptr == '0);           // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && ptr != PW'(DEPTH - 1)) |=> ptr == $past(ptr) + 1'b1); // R6

  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(wen));                                              // R7

  AST_NO_WEN_STALL: assert property (@(posedge clk) disable iff (!rst_s)
    !smp_vld |-> wen == '0);                                     // R7

  AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    primed |=> primed);                                          // R2

  AST_PRIME_AT_LAP: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(primed) |-> ptr == '0);                                // R2

endmodule

bind fft_fb_delay fft_fb_delay_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_s(rst_s), .smp_vld(smp_vld), .dout_vld(dout_vld),
  .primed(primed), .ptr(ptr), .wen(wen)
);

// File: tb/sim_fft_fb_delay.sv
`timescale 1ns/1ps
module sim_fft_fb_delay;
  localparam int W  = 12;
  localparam int DA = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, vld, sel;
  logic [W-1:0] ir, ii, dr, di;
  logic [W-1:0] ar, ai, br, bi;
  logic av, bv;

  int n_run = 0;
  int n_fail = 0;
  logic [2*W-1:0] qa[$];
  logic [2*W-1:0] qb[$];

  fft_fb_delay #(.DEPTH(DA), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(vld), .src_sel(sel),
    .smp_re(ir), .smp_im(ii), .dif_re(dr), .dif_im(di),
    .dout_re(ar), .dout_im(ai), .dout_vld(av));

  fft_fb_delay #(.DEPTH(1), .W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .smp_vld(vld), .src_sel(sel),
    .smp_re(ir), .smp_im(ii), .dif_re(dr), .dif_im(di),
    .dout_re(br), .dout_im(bi), .dout_vld(bv));

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare one instance against its queue
  task automatic mon(input int depth, input bit v, input bit ov,
                     input logic [2*W-1:0] got, input string tag,
                     inout logic [2*W-1:0] q[$]);
    logic [2*W-1:0] exp;
    if (!v) begin
      chk(ov == 1'b0, "R5", 64'(ov), 64'd0);
    end else if (q.size() == depth) begin
      exp = q.pop_front();
      chk(ov == 1'b1, "R2", 64'(ov), 64'd1);
      chk(got == exp, tag, 64'(got), 64'(exp));
    end else begin
      chk(ov == 1'b0, "R2", 64'(ov), 64'd0);
    end
  endtask

  // driver: applies one cycle, pushes the expected stored word
  task automatic step(input bit v, input bit s, input string tag);
    @(negedge clk);
    vld = v; sel = s;
    ir = W'($urandom); ii = W'($urandom);
    dr = W'($urandom); di = W'($urandom);
    #1;
    mon(DA, v, av, {ar, ai}, tag, qa);
    mon(1, v, bv, {br, bi}, "R8", qb);
    if (v) begin
      qa.push_back(s ? {dr, di} : {ir, ii});
      qb.push_back(s ? {dr, di} : {ir, ii});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b1; sel = 1'b0;
    #1;
    chk(av == 1'b0, "R1", 64'(av), 64'd0);
    chk(bv == 1'b0, "R1", 64'(bv), 64'd0);
    qa.delete(); qb.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1; vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; vld = 1'b0; sel = 1'b0;
    ir = '0; ii = '0; dr = '0; di = '0;
    do_reset();
    // R1: first valid cycle after reset gives no valid output
    step(1'b1, 1'b0, "R1");
    // R6: unbroken stream over several pointer laps
    for (int k = 0; k < 4 * DA; k++) step(1'b1, 1'b0, "R6");
    // R4: alternate source selection
    for (int k = 0; k < 3 * DA; k++) step(1'b1, k[0], "R4");
    // R5/R7: random stall gaps
    for (int k = 0; k < 300; k++) step(($urandom % 3) != 0, $urandom % 2, "R7");
    // R3: long stall then resume
    for (int k = 0; k < 10; k++) step(1'b0, 1'b0, "R5");
    for (int k = 0; k < 2 * DA; k++) step(1'b1, 1'b1, "R3");
    // R2: reset mid-run, refill with gaps
    do_reset();
    for (int k = 0; k < 5 * DA; k++) step(($urandom % 2) != 0, 1'b0, "R2");
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule